// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Unit

This block is the interrupt front end of an 8-bit accumulator core. Four sources can ask for service: the combined timer-0/half-second tick, timer 1, an asynchronous external pin, and a software trap raised by an instruction. Hardware sources pass through a three-bit enable value and a global mask flag that the block owns. The highest-priority pending source is chosen and its fixed 20-bit entry point is handed to the core as a 6-bit program page and a 14-bit program counter.

Around each dispatch the block saves the interrupted context itself. It writes four bytes onto a stack that grows toward lower addresses: the low PC byte first, then the high PC bits, then the program page, and last the status byte. It then tells the core the new stack pointer. On a return request it reads the same four bytes back in the opposite order and hands the core the restored context and stack pointer. The stack RAM is reached through a plain byte port whose read data is returned in the same cycle as the address.

While the core is halted in stop mode, no source is dispatched. A rising edge on the external pin raises a wake strobe so the core can restart its clock.

Top module: `irq_vector_unit`

## Requirements
- R1: `en_bits` bit 0 enables the timer-0/tick source, bit 1 enables timer 1 and bit 2 enables the external source. A request on a disabled source is not dispatched but stays pending, and it is dispatched once its bit is set.
- R2: Among enabled pending hardware requests, timer-0/tick wins over timer 1, which wins over external. The software trap ranks below all three. Requests that lose remain pending and are served one after another.
- R3: `vec_page` is 3 on every dispatch. `vec_pc` is 0x3FF0 for timer-0/tick, 0x3FE0 for timer 1, 0x3FD0 for external and 0x3FC0 for the software trap. `vec_sets_page` is 1 only for the software trap.
- R4: `i_flag` is 1 from the cycle after `vec_load`. While it is 1, hardware requests are not dispatched and stay pending.
- R5: Entry writes four bytes at addresses SP, SP-1, SP-2 and SP-3, in this order: PC[7:0], {2'b0, PC[13:8]}, {2'b0, page}, then status. `sp_next` is SP-4 when `vec_load` is 1.
- R6: A return reads SP+1, SP+2, SP+3 and SP+4, which give status, page, PC high and PC low. `ret_status` is the stored status with bit 4 (the mask bit) cleared. `sp_next` is SP+4. `i_flag` is 0 from the cycle after `ret_load`.
- R7: A software trap is dispatched even when `i_flag` is 1.
- R8: While `stop_mode` is 1, nothing is dispatched and no return is started. `wake` pulses only on a synchronised rising edge of `ext_pin`.
- R9: `ext_pin` passes through two synchroniser flops and an edge detector. A pin held high produces exactly one request.
- R10: `vec_load` appears 6 clock edges after the edge that samples a one-cycle timer or trap pulse, and 8 edges after the external pin rises.
- R11: After reset, `busy`, `i_flag`, `vec_load`, `ret_load`, `stk_we`, `stk_re` and `sp_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_bits | input | 3 | Source enables: bit0 tick/T0, bit1 T1, bit2 external |
| t0_req | input | 1 | Timer-0/tick overflow pulse |
| t1_req | input | 1 | Timer-1 overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| swi_req | input | 1 | Software trap pulse from the decoder |
| rti_req | input | 1 | Return-from-interrupt start pulse |
| stop_mode | input | 1 | Core is halted |
| cur_pc | input | 14 | Program counter to save |
| cur_page | input | 6 | Program page to save |
| cur_status | input | 8 | Status byte to save |
| cur_sp | input | 8 | Current stack pointer |
| stk_addr | output | 8 | Stack RAM address |
| stk_we | output | 1 | Stack write strobe |
| stk_wdata | output | 8 | Stack write byte |
| stk_re | output | 1 | Stack read strobe |
| stk_rdata | input | 8 | Stack read byte, valid in the address cycle |
| busy | output | 1 | Save or restore sequence running |
| i_flag | output | 1 | Global mask flag |
| vec_load | output | 1 | One-cycle strobe: load vector into page:PC |
| vec_page | output | 6 | Vector program page |
| vec_pc | output | 14 | Vector program counter |
| vec_sets_page | output | 1 | Also load the page register (software trap) |
| ret_load | output | 1 | One-cycle strobe: load restored context |
| ret_pc | output | 14 | Restored program counter |
| ret_page | output | 6 | Restored page for both page registers |
| ret_status | output | 8 | Restored status byte |
| sp_wr | output | 1 | Stack pointer update strobe |
| sp_next | output | 8 | New stack pointer |
| wake | output | 1 | Restart strobe from stop mode |

## Verification
Timer and trap pulses give `vec_load` six edges after the sampling edge, and a rising external pin gives it eight edges after. `ret_load` follows five edges after the edge that accepts `rti_req`. The stack pointer and the mask flag change one edge after either strobe. The bench counts rising edges and records the edge count at which each strobe is seen, sampling half a period after the edge. It checks the latencies exactly against these figures. It reads stack contents, `sp_next` and `i_flag` only after the edge that completes the update. For "not dispatched" claims it watches a fixed window of at least 15 cycles for any `vec_load`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int N_HW = 3;

  typedef enum logic [1:0] {
    SRC_T0  = 2'd0,
    SRC_T1  = 2'd1,
    SRC_EXT = 2'd2,
    SRC_SWI = 2'd3
  } irq_src_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PCL,
    ST_PUSH_PCH,
    ST_PUSH_PG,
    ST_PUSH_ST,
    ST_VEC,
    ST_POP_ST,
    ST_POP_PG,
    ST_POP_PCH,
    ST_POP_PCL,
    ST_RESTORE
  } seq_st_e;

  localparam logic [15:0] VEC_TOP  = 16'h3FF0;
  localparam int          VEC_SHFT = 4;

  // entry offsets step down by 16 bytes in priority order
  function automatic logic [15:0] vec_of(irq_src_e s);
    return VEC_TOP - (16'(s) << VEC_SHFT);
  endfunction

endpackage

// File: rtl/irqv_sync_edge.sv
module irqv_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/irqv_pend_pick.sv
module irqv_pend_pick
  import irqv_pkg::*;
#(
  parameter int NH = N_HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NH-1:0] hw_set,
  input  logic          swi_set,
  input  logic [NH-1:0] en_bits,
  input  logic          mask,
  input  logic          accept,
  output logic          take_valid,
  output irq_src_e      take_src
);
  localparam int SWI_IDX = NH;

  logic [NH:0] pend_q, pend_n, set_v, clr_v, cen_v;

  assign set_v = {swi_set, hw_set};

  for (genvar g = 0; g <= NH; g++) begin : g_pend
    assign clr_v[g]  = accept && (int'(take_src) == g);
    assign cen_v[g]  = set_v[g] | clr_v[g];
    assign pend_n[g] = set_v[g] | (pend_q[g] & ~clr_v[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[g] <= 1'b0;
      else if (cen_v[g]) pend_q[g] <= pend_n[g];
    end
  end

  // lowest index wins: loop from the bottom of the order upward
  always_comb begin
    take_valid = pend_q[SWI_IDX];
    take_src   = SRC_SWI;
    if (!mask) begin
      for (int i = NH - 1; i >= 0; i--) begin
        if (pend_q[i] && en_bits[i]) begin
          take_valid = 1'b1;
          take_src   = irq_src_e'(2'(i));
        end
      end
    end
  end
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
  import irqv_pkg::*;
#(
  parameter int PC_W     = 14,
  parameter int PG_W     = 6,
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int MASK_BIT = 4,
  parameter int VEC_PG   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_valid,
  input  irq_src_e        take_src,
  input  logic            rti_req,
  input  logic            stop_mode,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PG_W-1:0] cur_page,
  input  logic [DW-1:0]   cur_status,
  input  logic [AW-1:0]   cur_sp,
  input  logic [DW-1:0]   stk_rdata,
  output logic            accept,
  output logic [AW-1:0]   stk_addr,
  output logic            stk_we,
  output logic [DW-1:0]   stk_wdata,
  output logic            stk_re,
  output logic            busy,
  output logic            i_flag,
  output logic            vec_load,
  output logic [PG_W-1:0] vec_page,
  output logic [PC_W-1:0] vec_pc,
  output logic            vec_sets_page,
  output logic            ret_load,
  output logic [PC_W-1:0] ret_pc,
  output logic [PG_W-1:0] ret_page,
  output logic [DW-1:0]   ret_status,
  output logic            sp_wr,
  output logic [AW-1:0]   sp_next
);
  localparam int          PCH_W    = PC_W - DW;
  localparam logic [DW-1:0] MASK_CLR = ~(DW'(1) << MASK_BIT);

  seq_st_e         st_q, st_n;
  logic [AW-1:0]   sp_q, sp_n;
  irq_src_e        src_q, src_n;
  logic [PC_W-1:0] pc_q, pc_n;
  logic [PG_W-1:0] pg_q, pg_n;
  logic [DW-1:0]   sr_q, sr_n;
  logic            if_q, if_n;

  always_comb begin
    st_n      = st_q;
    sp_n      = sp_q;
    src_n     = src_q;
    pc_n      = pc_q;
    pg_n      = pg_q;
    sr_n      = sr_q;
    if_n      = if_q;
    stk_addr  = sp_q;
    stk_we    = 1'b0;
    stk_wdata = '0;
    stk_re    = 1'b0;
    accept    = 1'b0;
    vec_load  = 1'b0;
    ret_load  = 1'b0;
    sp_wr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!stop_mode) begin
          if (rti_req) begin
            st_n = ST_POP_ST;
            sp_n = cur_sp;
          end else if (take_valid) begin
            accept = 1'b1;
            st_n   = ST_PUSH_PCL;
            sp_n   = cur_sp;
            src_n  = take_src;
            pc_n   = cur_pc;
            pg_n   = cur_page;
            sr_n   = cur_status;
          end
        end
      end
      ST_PUSH_PCL: begin
        stk_we    = 1'b1;
        stk_wdata = pc_q[DW-1:0];
        sp_n      = sp_q - AW'(1);
        st_n      = ST_PUSH_PCH;
      end
      ST_PUSH_PCH: begin
        stk_we    = 1'b1;
        stk_wdata = DW'(pc_q[PC_W-1:DW]);
        sp_n      = sp_q - AW'(1);
        st_n      = ST_PUSH_PG;
      end
      ST_PUSH_PG: begin
        stk_we    = 1'b1;
        stk_wdata = DW'(pg_q);
        sp_n      = sp_q - AW'(1);
        st_n      = ST_PUSH_ST;
      end
      ST_PUSH_ST: begin
        stk_we    = 1'b1;
        stk_wdata = sr_q;
        sp_n      = sp_q - AW'(1);
        st_n      = ST_VEC;
      end
      ST_VEC: begin
        vec_load = 1'b1;
        sp_wr    = 1'b1;
        if_n     = 1'b1;
        st_n     = ST_IDLE;
      end
      ST_POP_ST: begin
        stk_addr = sp_q + AW'(1);
        stk_re   = 1'b1;
        sr_n     = stk_rdata;
        sp_n     = sp_q + AW'(1);
        st_n     = ST_POP_PG;
      end
      ST_POP_PG: begin
        stk_addr = sp_q + AW'(1);
        stk_re   = 1'b1;
        pg_n     = stk_rdata[PG_W-1:0];
        sp_n     = sp_q + AW'(1);
        st_n     = ST_POP_PCH;
      end
      ST_POP_PCH: begin
        stk_addr           = sp_q + AW'(1);
        stk_re             = 1'b1;
        pc_n[PC_W-1:DW]    = stk_rdata[PCH_W-1:0];
        sp_n               = sp_q + AW'(1);
        st_n               = ST_POP_PCL;
      end
      ST_POP_PCL: begin
        stk_addr     = sp_q + AW'(1);
        stk_re       = 1'b1;
        pc_n[DW-1:0] = stk_rdata;
        sp_n         = sp_q + AW'(1);
        st_n         = ST_RESTORE;
      end
      ST_RESTORE: begin
        ret_load = 1'b1;
        sp_wr    = 1'b1;
        if_n     = 1'b0;
        st_n     = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sp_q  <= '0;
      src_q <= SRC_T0;
      pc_q  <= '0;
      pg_q  <= '0;
      sr_q  <= '0;
      if_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      sp_q  <= sp_n;
      src_q <= src_n;
      pc_q  <= pc_n;
      pg_q  <= pg_n;
      sr_q  <= sr_n;
      if_q  <= if_n;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign i_flag        = if_q;
  assign vec_page      = PG_W'(VEC_PG);
  assign vec_pc        = PC_W'(vec_of(src_q));
  assign vec_sets_page = (src_q == SRC_SWI);
  assign ret_pc        = pc_q;
  assign ret_page      = pg_q;
  assign ret_status    = sr_q & MASK_CLR;
  assign sp_next       = sp_q;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int PC_W        = 14,
  parameter int PG_W        = 6,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int MASK_BIT    = 4,
  parameter int VEC_PG      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      en_bits,
  input  logic            t0_req,
  input  logic            t1_req,
  input  logic            ext_pin,
  input  logic            swi_req,
  input  logic            rti_req,
  input  logic            stop_mode,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PG_W-1:0] cur_page,
  input  logic [DW-1:0]   cur_status,
  input  logic [AW-1:0]   cur_sp,
  output logic [AW-1:0]   stk_addr,
  output logic            stk_we,
  output logic [DW-1:0]   stk_wdata,
  output logic            stk_re,
  input  logic [DW-1:0]   stk_rdata,
  output logic            busy,
  output logic            i_flag,
  output logic            vec_load,
  output logic [PG_W-1:0] vec_page,
  output logic [PC_W-1:0] vec_pc,
  output logic            vec_sets_page,
  output logic            ret_load,
  output logic [PC_W-1:0] ret_pc,
  output logic [PG_W-1:0] ret_page,
  output logic [DW-1:0]   ret_status,
  output logic            sp_wr,
  output logic [AW-1:0]   sp_next,
  output logic            wake
);
  // reset: asserted at once, released after two clean edges
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic     ext_rise, take_valid, accept;
  irq_src_e take_src;

  irqv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .pin  (ext_pin),
    .rise (ext_rise)
  );

  irqv_pend_pick #(.NH(N_HW)) u_pick (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .hw_set    ({ext_rise, t1_req, t0_req}),
    .swi_set   (swi_req),
    .en_bits   (en_bits),
    .mask      (i_flag),
    .accept    (accept),
    .take_valid(take_valid),
    .take_src  (take_src)
  );

  irqv_seq #(
    .PC_W(PC_W), .PG_W(PG_W), .DW(DW), .AW(AW),
    .MASK_BIT(MASK_BIT), .VEC_PG(VEC_PG)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .take_valid   (take_valid),
    .take_src     (take_src),
    .rti_req      (rti_req),
    .stop_mode    (stop_mode),
    .cur_pc       (cur_pc),
    .cur_page     (cur_page),
    .cur_status   (cur_status),
    .cur_sp       (cur_sp),
    .stk_rdata    (stk_rdata),
    .accept       (accept),
    .stk_addr     (stk_addr),
    .stk_we       (stk_we),
    .stk_wdata    (stk_wdata),
    .stk_re       (stk_re),
    .busy         (busy),
    .i_flag       (i_flag),
    .vec_load     (vec_load),
    .vec_page     (vec_page),
    .vec_pc       (vec_pc),
    .vec_sets_page(vec_sets_page),
    .ret_load     (ret_load),
    .ret_pc       (ret_pc),
    .ret_page     (ret_page),
    .ret_status   (ret_status),
    .sp_wr        (sp_wr),
    .sp_next      (sp_next)
  );

  assign wake = stop_mode & ext_rise;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int PG_W   = 6,
  parameter int AW     = 8,
  parameter int VEC_PG = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_load,
  input logic            ret_load,
  input logic            stk_we,
  input logic            stk_re,
  input logic [AW-1:0]   stk_addr,
  input logic            i_flag,
  input logic [PG_W-1:0] vec_page,
  input logic            busy,
  input logic            stop_mode
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_load, ret_load, stk_we, stk_re})); // R5
  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> i_flag); // R4
  AST_MASK_OFF_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_load |=> !i_flag); // R6
  AST_VEC_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (vec_page == PG_W'(VEC_PG))); // R3
  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |-> (stk_addr == AW'($past(stk_addr) - AW'(1)))); // R5
  AST_POP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_re && $past(stk_re)) |-> (stk_addr == AW'($past(stk_addr) + AW'(1)))); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !busy) |=> !busy); // R8
endmodule

bind irq_vector_unit irqv_chk #(.PG_W(PG_W), .AW(AW), .VEC_PG(VEC_PG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vec_load (vec_load),
  .ret_load (ret_load),
  .stk_we   (stk_we),
  .stk_re   (stk_re),
  .stk_addr (stk_addr),
  .i_flag   (i_flag),
  .vec_page (vec_page),
  .busy     (busy),
  .stop_mode(stop_mode)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  en_bits;
  logic        t0_req, t1_req, ext_pin, swi_req, rti_req, stop_mode;
  logic [13:0] cur_pc;
  logic [5:0]  cur_page;
  logic [7:0]  cur_status, cur_sp;
  logic [7:0]  stk_addr, stk_wdata, stk_rdata, sp_next;
  logic        stk_we, stk_re, busy, i_flag, vec_load, vec_sets_page;
  logic        ret_load, sp_wr, wake;
  logic [5:0]  vec_page, ret_page;
  logic [13:0] vec_pc, ret_pc;
  logic [7:0]  ret_status;

  always #2 clk = ~clk;

  irq_vector_unit u0 (.*);

  // stack RAM and core stack pointer models
  logic [7:0] mem [256];
  assign stk_rdata = mem[stk_addr];
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (sp_wr)  cur_sp <= sp_next;
  end

  int n_chk = 0, n_bad = 0;
  int edge_cnt = 0, vec_cnt = 0, ret_cnt = 0, wake_cnt = 0, vec_edge = 0;
  logic [13:0] v_pc;
  logic [5:0]  v_pg;
  logic        v_sp;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;
  always @(negedge clk) begin
    if (vec_load) begin
      vec_cnt  <= vec_cnt + 1;
      vec_edge <= edge_cnt;
      v_pc     <= vec_pc;
      v_pg     <= vec_page;
      v_sp     <= vec_sets_page;
    end
    if (ret_load) ret_cnt  <= ret_cnt + 1;
    if (wake)     wake_cnt <= wake_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] which);
    @(negedge clk);
    t0_req = which[0]; t1_req = which[1]; swi_req = which[3];
    if (which[2]) ext_pin = 1'b1;
    @(negedge clk);
    t0_req = 1'b0; t1_req = 1'b0; swi_req = 1'b0;
    if (which[2]) begin
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
    end
  endtask

  task automatic wait_vec(input int base);
    for (int n = 0; n < 60 && vec_cnt == base; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_rti(input string tag, input logic [7:0] exp_sp);
    int base;
    base = ret_cnt;
    @(negedge clk); rti_req = 1'b1;
    @(negedge clk); rti_req = 1'b0;
    for (int n = 0; n < 40 && ret_cnt == base; n++) @(negedge clk);
    chk({tag, " ret_pc"}, ret_pc, 14'h1234);
    chk({tag, " ret_page"}, ret_page, 6'h01);
    chk({tag, " ret_status mask cleared"}, ret_status, 8'hA5);
    @(negedge clk);
    chk({tag, " i_flag cleared"}, i_flag, 1'b0);
    chk({tag, " sp restored"}, cur_sp, exp_sp);
  endtask

  // {en[2:0], src[1:0] (0 t0,1 t1,2 ext,3 swi), latency[3:0], pc[13:0]}
  localparam logic [22:0] TBL [4] = '{
    {3'b001, 2'd0, 4'd6, 14'h3FF0},
    {3'b010, 2'd1, 4'd6, 14'h3FE0},
    {3'b100, 2'd2, 4'd8, 14'h3FD0},
    {3'b000, 2'd3, 4'd6, 14'h3FC0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base, start;
    rst_n = 1'b0; en_bits = 3'b000;
    t0_req = 0; t1_req = 0; ext_pin = 0; swi_req = 0; rti_req = 0; stop_mode = 0;
    cur_pc = 14'h1234; cur_page = 6'h01; cur_status = 8'hB5; cur_sp = 8'hFF;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 i_flag", i_flag, 0);
    chk("R11 strobes", {vec_load, ret_load, stk_we, stk_re, sp_wr}, 0);

    // table: one source each, check vector, latency, stack frame, return
    for (int k = 0; k < 4; k++) begin
      logic [22:0] e;
      logic [3:0]  bits;
      e = TBL[k];
      en_bits = e[22:20];
      bits = 4'b0001 << e[19:18];
      base = vec_cnt;
      @(negedge clk);
      start = edge_cnt;
      pulse(bits);
      wait_vec(base);
      chk("R3 vec_pc", v_pc, e[13:0]);
      chk("R3 vec_page", v_pg, 6'd3);
      chk("R3 vec_sets_page", v_sp, e[19:18] == 2'd3);
      chk("R10 latency", vec_edge - start - 1, e[17:14]);
      chk("R5 pcl@FF", mem[8'hFF], 8'h34);
      chk("R5 pch@FE", mem[8'hFE], 8'h12);
      chk("R5 page@FD", mem[8'hFD], 8'h01);
      chk("R5 status@FC", mem[8'hFC], 8'hB5);
      chk("R5 sp_next", cur_sp, 8'hFB);
      chk("R4 i_flag set", i_flag, 1);
      do_rti("R6", 8'hFF);
    end

    // R2 priority with all three hardware sources together
    en_bits = 3'b111;
    base = vec_cnt;
    pulse(4'b0111);
    wait_vec(base);
    chk("R2 first T0", v_pc, 14'h3FF0);
    do_rti("R2a", 8'hFF);
    wait_vec(base + 1);
    chk("R2 second T1", v_pc, 14'h3FE0);
    do_rti("R2b", 8'hFF);
    wait_vec(base + 2);
    chk("R2 third EXT", v_pc, 14'h3FD0);
    do_rti("R2c", 8'hFF);

    // R1 disabled source held pending until enabled
    en_bits = 3'b001;
    base = vec_cnt;
    pulse(4'b0010);
    repeat (20) @(negedge clk);
    chk("R1 disabled T1 not taken", vec_cnt, base);
    en_bits = 3'b010;
    wait_vec(base);
    chk("R1 T1 taken once enabled", v_pc, 14'h3FE0);
    do_rti("R1", 8'hFF);

    // R4 mask holds a later request pending
    en_bits = 3'b111;
    base = vec_cnt;
    pulse(4'b0001);
    wait_vec(base);
    pulse(4'b0010);
    repeat (20) @(negedge clk);
    chk("R4 T1 held while masked", vec_cnt, base + 1);
    do_rti("R4", 8'hFF);
    wait_vec(base + 1);
    chk("R4 T1 after return", v_pc, 14'h3FE0);
    do_rti("R4b", 8'hFF);

    // R7 software trap nests through the mask
    base = vec_cnt;
    pulse(4'b0001);
    wait_vec(base);
    pulse(4'b1000);
    wait_vec(base + 1);
    chk("R7 trap vector under mask", v_pc, 14'h3FC0);
    chk("R7 trap sets page", v_sp, 1);
    chk("R7 nested status@F8", mem[8'hF8], 8'hB5);
    chk("R7 nested sp", cur_sp, 8'hF7);
    do_rti("R7a", 8'hFB);
    do_rti("R7b", 8'hFF);

    // R9 pin held high gives one request only
    base = vec_cnt;
    @(negedge clk); ext_pin = 1'b1;
    wait_vec(base);
    chk("R9 ext vector", v_pc, 14'h3FD0);
    do_rti("R9", 8'hFF);
    repeat (20) @(negedge clk);
    chk("R9 no retrigger while high", vec_cnt, base + 1);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R8 stop mode: no dispatch, wake only on external edge
    stop_mode = 1'b1;
    base = vec_cnt;
    start = wake_cnt;
    pulse(4'b0001);
    repeat (15) @(negedge clk);
    chk("R8 no dispatch in stop", vec_cnt, base);
    chk("R8 no wake from timer", wake_cnt, start);
    pulse(4'b0100);
    repeat (10) @(negedge clk);
    chk("R8 wake on ext edge", wake_cnt, start + 1);
    chk("R8 still no dispatch", vec_cnt, base);
    stop_mode = 1'b0;
    wait_vec(base);
    chk("R8 T0 first after stop", v_pc, 14'h3FF0);
    do_rti("R8a", 8'hFF);
    wait_vec(base + 1);
    chk("R8 ext after T0", v_pc, 14'h3FD0);
    do_rti("R8b", 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule